// File: doc/BRIEF.md
# OOK Pulse-Width Wake-Up Frame Decoder

This block sits behind an envelope detector in an always-on wake-up path. It samples the demodulated one-bit baseband line with a clock of about ten samples per symbol time T. It recovers each symbol from the length of its high pulse: a short pulse is a '0' and a pulse of about twice that length is a '1'. Counters take the place of external delay elements. Symbols inside a frame are separated by short low gaps. A long low gap closes the frame, and an even longer idle gap separates one frame from the next.

A frame starts with a fixed 8-symbol preamble. A selector symbol follows and picks an address of 16 or 64 symbols, and then the address comes. The decoder passes each address symbol to a downstream comparator as a one-cycle strobe that carries the bit and its 0-based index. When the frame ends it gives one end-of-frame strobe with a verdict. A broken frame gives an end-of-frame strobe marked invalid. The decoder then ignores the line until the line has stayed low for a full idle gap.

Top module: `ook_wake_decoder`

## Requirements
- R1: A high pulse of N samples decodes as '0' when T_CLKS/2 <= N < 3*T_CLKS/2, and as '1' when 3*T_CLKS/2 <= N <= 3*T_CLKS. With the default T_CLKS = 10 these ranges are 5..14 and 15..30.
- R2: A high pulse shorter than T_CLKS/2 or longer than 3*T_CLKS is a frame error. The decoder reports it with eof_stb=1 and eof_ok=0 two cycles after the first low sample.
- R3: The first eight pulses of a frame must match the preamble 1010_0110, sent most significant bit first. The first pulse that does not match gives the error report of R2 at that pulse.
- R4: The pulse after the preamble is the selector: 1 requests 64 address symbols and 0 requests 16. sym_idx never reaches the requested length.
- R5: Each accepted address pulse gives sym_stb high for exactly one cycle, two cycles after the first low sample. sym_bit carries the decoded value and sym_idx the 0-based position (0, 1, 2, ...).
- R6: A low run of 2*T_CLKS+1 samples ends the frame. If the address count equals the requested length, eof_stb pulses with eof_ok=1 and eof_sel equal to the selector, 2*T_CLKS+2 cycles after the first low sample.
- R7: The frame is an error in three cases: a frame end with fewer address symbols than requested, an address pulse beyond the requested length, or a frame end during the preamble or the selector. Each gives eof_stb=1 with eof_ok=0, with the timing of R2 or R6.
- R8: After any end-of-frame report, the decoder drops every pulse and gap without output until the line has been low for 5*T_CLKS consecutive samples. It then accepts a new frame.
- R9: sym_stb and eof_stb are never high in the same cycle, and each frame gives at most one eof_stb.
- R10: Reset is synchronous and active high. After it, both strobes are low and the decoder waits for a new preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, about 10/T |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Demodulated baseband line |
| sym_stb | output | 1 | One-cycle address symbol strobe |
| sym_bit | output | 1 | Decoded address symbol value |
| sym_idx | output | $clog2(LONG_LEN) | 0-based address symbol index |
| eof_stb | output | 1 | One-cycle end-of-frame strobe |
| eof_ok | output | 1 | Frame verdict: 1 for a valid frame |
| eof_sel | output | 1 | Selector of the frame: 1 for 64 symbols |

## Verification
Every pulse result, whether a symbol strobe or an error report, is due on the second cycle after the line is first sampled low. A frame-end verdict is due on cycle 2*T_CLKS+2 of the low run, which is cycle 22 at the default T_CLKS. The bench drives the line on falling clock edges and counts each cycle of every high and low run. At every falling edge of the run it compares both strobes against a model, expecting a strobe only on those exact cycles and silence on all others. In-frame gaps are kept at 19 samples or fewer and frame-end gaps at 22 or more, so every due cycle falls inside the run that caused it.

// File: rtl/ook_wake_pkg.sv
package ook_wake_pkg;

    // Frame parser states
    typedef enum logic [2:0] {
        ST_ARMED    = 3'd0,
        ST_PREAMBLE = 3'd1,
        ST_SELECT   = 3'd2,
        ST_ADDR     = 3'd3,
        ST_HOLD     = 3'd4
    } frame_st_e;

    // Class of one measured high pulse
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_BAD  = 2'd2
    } sym_cls_e;

endpackage

// File: rtl/ook_pulse_meter.sv
module ook_pulse_meter
    import ook_wake_pkg::*;
#(
    parameter int T_CLKS = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_in,
    output logic     pulse_vld,
    output sym_cls_e pulse_cls,
    output logic     gap_end,
    output logic     idle_seen
);

    localparam int ZERO_MIN = T_CLKS / 2;
    localparam int ONE_MIN  = (3 * T_CLKS) / 2;
    localparam int ONE_MAX  = 3 * T_CLKS;
    localparam int GAP_END  = 2 * T_CLKS + 1;
    localparam int IDLE_LEN = 5 * T_CLKS;
    localparam int RUN_MAX  = IDLE_LEN + 1;
    localparam int RUN_W    = $clog2(RUN_MAX + 1);

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
        logic             pulse_vld;
        sym_cls_e         cls;
        logic             gap_end;
        logic             idle;
    } meter_s;

    meter_s q, d;

    function automatic sym_cls_e classify(input logic [RUN_W-1:0] n);
        int len;
        len = int'(n);
        if (len >= ZERO_MIN && len < ONE_MIN) return SYM_ZERO;
        if (len >= ONE_MIN && len <= ONE_MAX) return SYM_ONE;
        return SYM_BAD;
    endfunction

    always_comb begin
        d           = q;
        d.pulse_vld = 1'b0;
        d.gap_end   = 1'b0;
        d.idle      = 1'b0;
        if (rx_in == q.lvl) begin
            if (q.run != RUN_W'(RUN_MAX)) begin
                d.run = q.run + 1'b1;
            end
        end else begin
            d.lvl = rx_in;
            d.run = RUN_W'(1);
            if (q.lvl) begin
                d.pulse_vld = 1'b1;
                d.cls       = classify(q.run);
            end
        end
        if (!rx_in && !q.lvl) begin
            if (d.run == RUN_W'(GAP_END)) d.gap_end = 1'b1;
            if (d.run == RUN_W'(IDLE_LEN)) d.idle = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.run <= RUN_W'(RUN_MAX);
        end else begin
            q <= d;
        end
    end

    assign pulse_vld = q.pulse_vld;
    assign pulse_cls = q.cls;
    assign gap_end   = q.gap_end;
    assign idle_seen = q.idle;

    // A pulse report follows a high sample and then a low sample
    p_pulse_edge_r1: assert property (@(posedge clk) disable iff (rst)
        pulse_vld |-> ($past(rx_in, 2) && !$past(rx_in)));

    // Frame-end marker only while the line is low
    p_gap_low_r6: assert property (@(posedge clk) disable iff (rst)
        gap_end |-> !$past(rx_in));

    // Idle marker only while the line is low, never together with frame end
    p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
        idle_seen |-> (!$past(rx_in) && !gap_end));

endmodule

// File: rtl/ook_frame_fsm.sv
module ook_frame_fsm
    import ook_wake_pkg::*;
#(
    parameter int              PRE_LEN   = 8,
    parameter logic [PRE_LEN-1:0] PREAMBLE = 8'hA6,
    parameter int              SHORT_LEN = 16,
    parameter int              LONG_LEN  = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pulse_vld,
    input  sym_cls_e                    pulse_cls,
    input  logic                        gap_end,
    input  logic                        idle_seen,
    output logic                        sym_stb,
    output logic                        sym_bit,
    output logic [$clog2(LONG_LEN)-1:0] sym_idx,
    output logic                        eof_stb,
    output logic                        eof_ok,
    output logic                        eof_sel
);

    localparam int IDX_W = $clog2(LONG_LEN);
    localparam int CNT_W = IDX_W + 1;

    typedef struct packed {
        frame_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic             sel;
        logic             sym_stb;
        logic             sym_bit;
        logic [IDX_W-1:0] sym_idx;
        logic             eof_stb;
        logic             eof_ok;
        logic             eof_sel;
    } fsm_s;

    fsm_s q, d;

    logic             pulse_one;
    logic             pulse_bad;
    logic             pre_bit;
    logic [CNT_W-1:0] pre_pos;
    logic [CNT_W-1:0] need;
    logic             fail;

    assign pulse_one = (pulse_cls == SYM_ONE);
    assign pulse_bad = (pulse_cls == SYM_BAD);
    assign need      = q.sel ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
    assign pre_pos   = (q.st == ST_PREAMBLE) ? q.cnt : '0;

    always_comb begin
        pre_bit = 1'b0;
        for (int i = 0; i < PRE_LEN; i++) begin
            if (pre_pos == CNT_W'(PRE_LEN - 1 - i)) pre_bit = PREAMBLE[i];
        end
    end

    always_comb begin
        d         = q;
        d.sym_stb = 1'b0;
        d.eof_stb = 1'b0;
        fail      = 1'b0;
        case (q.st)
            ST_ARMED, ST_PREAMBLE: begin
                if (pulse_vld) begin
                    if (pulse_bad || (pulse_one != pre_bit)) begin
                        fail = 1'b1;
                    end else if (pre_pos == CNT_W'(PRE_LEN - 1)) begin
                        d.st = ST_SELECT;
                    end else begin
                        d.st  = ST_PREAMBLE;
                        d.cnt = pre_pos + 1'b1;
                    end
                end else if (gap_end && (q.st == ST_PREAMBLE)) begin
                    fail = 1'b1;
                end
            end
            ST_SELECT: begin
                if (pulse_vld) begin
                    if (pulse_bad) begin
                        fail = 1'b1;
                    end else begin
                        d.sel = pulse_one;
                        d.st  = ST_ADDR;
                        d.cnt = '0;
                    end
                end else if (gap_end) begin
                    fail = 1'b1;
                end
            end
            ST_ADDR: begin
                if (pulse_vld) begin
                    if (pulse_bad || (q.cnt == need)) begin
                        fail = 1'b1;
                    end else begin
                        d.sym_stb = 1'b1;
                        d.sym_bit = pulse_one;
                        d.sym_idx = q.cnt[IDX_W-1:0];
                        d.cnt     = q.cnt + 1'b1;
                    end
                end else if (gap_end) begin
                    if (q.cnt == need) begin
                        d.eof_stb = 1'b1;
                        d.eof_ok  = 1'b1;
                        d.eof_sel = q.sel;
                        d.st      = ST_HOLD;
                    end else begin
                        fail = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (idle_seen) d.st = ST_ARMED;
            end
            default: d.st = ST_HOLD;
        endcase
        if (fail) begin
            d.st      = ST_HOLD;
            d.eof_stb = 1'b1;
            d.eof_ok  = 1'b0;
            d.eof_sel = q.sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign sym_stb = q.sym_stb;
    assign sym_bit = q.sym_bit;
    assign sym_idx = q.sym_idx;
    assign eof_stb = q.eof_stb;
    assign eof_ok  = q.eof_ok;
    assign eof_sel = q.eof_sel;

    // Address strobes come only out of the address phase
    p_sym_only_addr_r5: assert property (@(posedge clk) disable iff (rst)
        q.sym_stb |-> ($past(q.st) == ST_ADDR));

    // Index stays below the length the selector asked for
    p_idx_bound_r4: assert property (@(posedge clk) disable iff (rst)
        q.sym_stb |-> (int'(q.sym_idx) < (q.sel ? LONG_LEN : SHORT_LEN)));

    // A good verdict is only given after a frame-end gap
    p_ok_after_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (q.eof_stb && q.eof_ok) |-> $past(gap_end));

    // Every report has a pulse or a gap as its cause
    p_eof_cause_r7: assert property (@(posedge clk) disable iff (rst)
        q.eof_stb |-> $past(pulse_vld || gap_end));

    // While holding, nothing comes out
    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_HOLD) |=> (!q.sym_stb && !q.eof_stb));

    // Strobes never overlap
    p_excl_strobes_r9: assert property (@(posedge clk) disable iff (rst)
        !(q.sym_stb && q.eof_stb));

    // Reset leaves both strobes low
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!q.sym_stb && !q.eof_stb));

endmodule

// File: rtl/ook_wake_decoder.sv
module ook_wake_decoder
    import ook_wake_pkg::*;
#(
    parameter int                 T_CLKS    = 10,
    parameter int                 PRE_LEN   = 8,
    parameter logic [PRE_LEN-1:0] PREAMBLE  = 8'hA6,
    parameter int                 SHORT_LEN = 16,
    parameter int                 LONG_LEN  = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rx_in,
    output logic                        sym_stb,
    output logic                        sym_bit,
    output logic [$clog2(LONG_LEN)-1:0] sym_idx,
    output logic                        eof_stb,
    output logic                        eof_ok,
    output logic                        eof_sel
);

    logic     pulse_vld;
    sym_cls_e pulse_cls;
    logic     gap_end;
    logic     idle_seen;

    ook_pulse_meter #(
        .T_CLKS (T_CLKS)
    ) u_meter (
        .clk       (clk),
        .rst       (rst),
        .rx_in     (rx_in),
        .pulse_vld (pulse_vld),
        .pulse_cls (pulse_cls),
        .gap_end   (gap_end),
        .idle_seen (idle_seen)
    );

    ook_frame_fsm #(
        .PRE_LEN   (PRE_LEN),
        .PREAMBLE  (PREAMBLE),
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pulse_vld (pulse_vld),
        .pulse_cls (pulse_cls),
        .gap_end   (gap_end),
        .idle_seen (idle_seen),
        .sym_stb   (sym_stb),
        .sym_bit   (sym_bit),
        .sym_idx   (sym_idx),
        .eof_stb   (eof_stb),
        .eof_ok    (eof_ok),
        .eof_sel   (eof_sel)
    );

endmodule

// File: tb/ook_wake_decoder_bench.sv
module ook_wake_decoder_bench;

    localparam int TC = 10;
    localparam logic [7:0] PRE = 8'hA6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b0;
    logic       sym_stb, sym_bit, eof_stb, eof_ok, eof_sel;
    logic [5:0] sym_idx;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R10";

    // model state: 0 armed, 1 preamble, 2 selector, 3 address, 4 hold
    int m_st = 0;
    int m_cnt = 0;
    bit m_sel = 0;

    always #5 clk = ~clk;

    ook_wake_decoder u_ook_wake_decoder (
        .clk(clk), .rst(rst), .rx_in(rx_in),
        .sym_stb(sym_stb), .sym_bit(sym_bit), .sym_idx(sym_idx),
        .eof_stb(eof_stb), .eof_ok(eof_ok), .eof_sel(eof_sel)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic int cls_of(int len);
        if (len >= TC / 2 && len < (3 * TC) / 2) return 0;
        if (len >= (3 * TC) / 2 && len <= 3 * TC) return 1;
        return 2;
    endfunction

    // kind: 0 none, 1 symbol, 2 error report
    task automatic model_pulse(int len, output int kind, output bit b, output int idx);
        int c;
        int need;
        c = cls_of(len);
        kind = 0; b = (c == 1); idx = 0;
        need = m_sel ? 64 : 16;
        case (m_st)
            0, 1: begin
                if (m_st == 0) m_cnt = 0;
                if (c == 2 || b != PRE[7 - m_cnt]) kind = 2;
                else begin
                    m_cnt++;
                    m_st = (m_cnt == 8) ? 2 : 1;
                end
            end
            2: if (c == 2) kind = 2; else begin m_sel = b; m_st = 3; m_cnt = 0; end
            3: if (c == 2 || m_cnt == need) kind = 2;
               else begin kind = 1; idx = m_cnt; m_cnt++; end
            default: ;
        endcase
        if (kind == 2) m_st = 4;
    endtask

    task automatic model_gap(output int kind, output bit ok);
        kind = 0; ok = 0;
        if (m_st == 1 || m_st == 2) begin kind = 2; m_st = 4; end
        else if (m_st == 3) begin
            kind = 2; ok = (m_cnt == (m_sel ? 64 : 16)); m_st = 4;
        end
    endtask

    // Drive one high pulse of hi samples, then lo low samples (lo<=19 or lo>=22, lo>=3)
    task automatic send_pulse(int hi, int lo);
        int pk, gk, pidx;
        bit pb, gok;
        model_pulse(hi, pk, pb, pidx);
        rx_in = 1'b1;
        for (int k = 1; k <= hi; k++) begin
            @(negedge clk);
            chk("R9", "sym_stb in high run", sym_stb, 0);
            chk("R9", "eof_stb in high run", eof_stb, 0);
        end
        rx_in = 1'b0;
        gk = 0; gok = 0;
        for (int k = 1; k <= lo; k++) begin
            @(negedge clk);
            if (k == 22) model_gap(gk, gok);
            if (k == 2) begin
                chk(cur_tag, "sym_stb after pulse", sym_stb, (pk == 1) ? 1 : 0);
                chk(cur_tag, "eof_stb after pulse", eof_stb, (pk == 2) ? 1 : 0);
                if (pk == 1) begin
                    chk("R5", "sym_bit", sym_bit, pb);
                    chk("R5", "sym_idx", sym_idx, pidx);
                end
                if (pk == 2) chk(cur_tag, "eof_ok on pulse error", eof_ok, 0);
            end else if (k == 22) begin
                chk("R9", "sym_stb at gap end", sym_stb, 0);
                chk(cur_tag, "eof_stb at gap end", eof_stb, (gk == 2) ? 1 : 0);
                if (gk == 2) begin
                    chk(cur_tag, "eof_ok at gap end", eof_ok, gok);
                    if (gok) chk("R6", "eof_sel", eof_sel, m_sel);
                end
            end else begin
                chk("R9", "sym_stb quiet", sym_stb, 0);
                chk("R9", "eof_stb quiet", eof_stb, 0);
            end
        end
        if (lo >= 5 * TC && m_st == 4) m_st = 0;
    endtask

    function automatic int hi_for(bit b);
        return b ? (17 + int'($urandom % 6)) : (8 + int'($urandom % 5));
    endfunction

    function automatic int in_lo();
        return 7 + int'($urandom % 7);
    endfunction

    task automatic send_frame(logic [7:0] pre, bit sel, logic [63:0] addr, int nsym, int end_lo);
        for (int i = 0; i < 8; i++) send_pulse(hi_for(pre[7 - i]), in_lo());
        send_pulse(hi_for(sel), (nsym == 0) ? end_lo : in_lo());
        for (int i = 0; i < nsym; i++)
            send_pulse(hi_for(addr[i]), (i == nsym - 1) ? end_lo : in_lo());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] a;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10", "sym_stb in reset", sym_stb, 0);
        chk("R10", "eof_stb in reset", eof_stb, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "sym_stb after reset", sym_stb, 0);
        chk("R10", "eof_stb after reset", eof_stb, 0);

        // R1 R4 R5 R6: valid short and long frames
        cur_tag = "R6";
        a = {$urandom, $urandom};
        send_frame(PRE, 1'b0, a, 16, 60);
        a = {$urandom, $urandom};
        send_frame(PRE, 1'b1, a, 64, 60);

        // R1: window boundaries 5,14 -> '0' and 15,30 -> '1'
        cur_tag = "R1";
        for (int i = 0; i < 8; i++) send_pulse(hi_for(PRE[7 - i]), in_lo());
        send_pulse(10, 9);
        send_pulse(5, 9); send_pulse(14, 9); send_pulse(15, 9); send_pulse(30, 9);
        for (int i = 4; i < 16; i++) send_pulse(hi_for(i[0]), (i == 15) ? 60 : in_lo());

        // R2: out-of-window pulses 4 and 31 in the address
        cur_tag = "R2";
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 8; i++) send_pulse(hi_for(PRE[7 - i]), in_lo());
            send_pulse(10, 9);
            for (int i = 0; i < 5; i++) send_pulse(hi_for(i[0]), in_lo());
            send_pulse((r == 0) ? 4 : 31, 9);
            for (int i = 0; i < 10; i++) send_pulse(hi_for(i[1]), (i == 9) ? 60 : in_lo());
        end

        // R3: preamble with last bit wrong
        cur_tag = "R3";
        send_frame(8'hA7, 1'b0, 64'h1234, 16, 60);

        // R7: short frame, overlong frame, gap inside preamble
        cur_tag = "R7";
        send_frame(PRE, 1'b0, 64'hBEEF, 15, 60);
        send_frame(PRE, 1'b0, 64'h1_BEEF, 17, 60);
        for (int i = 0; i < 4; i++) send_pulse(hi_for(PRE[7 - i]), (i == 3) ? 30 : in_lo());
        // R8: a full valid frame arriving before the idle gap is dropped
        cur_tag = "R8";
        send_frame(PRE, 1'b0, 64'h5A5A, 16, 60);
        send_frame(PRE, 1'b0, 64'hC3C3, 16, 30);
        send_frame(PRE, 1'b1, 64'hFFFF_0000, 64, 60);
        send_frame(PRE, 1'b0, 64'h0F0F, 16, 60);

        // Random frames
        for (int f = 0; f < 12; f++) begin
            bit s;
            int n, lo;
            s = 1'($urandom % 2);
            n = s ? 64 : 16;
            case ($urandom % 4)
                0: n = n - 1;
                1: n = n + 1;
                default: ;
            endcase
            lo = ($urandom % 3 == 0) ? (25 + int'($urandom % 15)) : (50 + int'($urandom % 20));
            a = {$urandom, $urandom};
            cur_tag = (n == (s ? 64 : 16)) ? "R6" : "R7";
            send_frame(PRE, s, a, n, lo);
        end
        send_frame(PRE, 1'b0, 64'h7777, 16, 60);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule